// File: doc/BRIEF.md
# Integer ALU with Stored Condition Flags

This block is the arithmetic and logic stage of a simple processor datapath. Each cycle it combines two operand words under a four-bit operation code. The result appears combinationally on `result`. Four condition flags are held in a register: negative (N), zero (Z), carry (C) and signed overflow (V). The register loads at the rising clock edge only when `set_flags` is high.

The carry flag feeds back as the carry-in for the carry-chained operations. This lets a wide number be added or subtracted one word at a time. Subtraction is formed as `a + ~b + 1`, so after a subtract C=1 means no borrow and C=0 means a borrow occurred. The logical and shift operations update only N and Z and keep C and V. Multiply, divide, rotates, arithmetic shifts, operand storage and instruction decoding belong to other blocks.

Top module: `alu_core`

## Requirements
- R1: Operation codes 0 (AND), 1 (XOR), 2 (OR) and 3 (bit-clear) produce `a & b`, `a ^ b`, `a | b` and `a & ~b` on `result`.
- R2: Operation codes 4 (add), 5 (subtract) and 6 (reverse subtract) produce `a + b`, `a - b` and `b - a` modulo 2^WIDTH. These three use no stored carry.
- R3: Code 9 (add with carry) produces `a + b + C`. Code 10 (subtract with borrow) produces `a + ~b + C`. C is the stored carry flag.
- R4: For codes 4, 5, 6, 9 and 10 with `set_flags` high, C is loaded with the carry out of the top bit of the adder. After an add, C=1 means the unsigned result wrapped. After a subtract, C=1 means no borrow.
- R5: For the same codes, V is loaded with the XOR of the carry into the top bit and the carry out of it. This is 1 exactly when the signed result overflowed.
- R6: For every code from 0 to 10 with `set_flags` high, N is loaded with the top bit of `result`. Z is loaded with 1 exactly when `result` is all zeros.
- R7: Code 7 shifts `a` left and code 8 shifts `a` right logically. The shift count is the low log2(WIDTH) bits of `b`; the higher bits of `b` are ignored.
- R8: Codes 0, 1, 2, 3, 7 and 8 leave C and V unchanged, even with `set_flags` high.
- R9: When `set_flags` is low at a rising edge, all four flags keep their values.
- R10: A synchronous active-high `rst` clears all four flags at the rising edge.
- R11: Codes 11 to 15 drive `result` to zero and leave all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, also the shift count source |
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Enables the flag update at the next edge |
| result | output | WIDTH | Combinational operation result |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag, also the carry-in of codes 9 and 10 |
| flag_v | output | 1 | Stored signed overflow flag |

## Verification
The only internal state is the four-bit flag register. A wrong flag is visible on the flag outputs one edge after the cycle that loaded it. A wrong C also shows up in `result` during the next add-with-carry or subtract-with-borrow. The reference model therefore tracks the flags across long chains of operations. It compares `result` inside every cycle and the flags just after every edge, so a fault shows up within one cycle of its cause.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_XOR = 4'd1,
        OP_OR  = 4'd2,
        OP_BIC = 4'd3,
        OP_ADD = 4'd4,
        OP_SUB = 4'd5,
        OP_RSB = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_ADC = 4'd9,
        OP_SBC = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_ARITH = 2'd2
    } op_class_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic op_class_e classify(input logic [3:0] code);
        case (code)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd7, 4'd8: classify = CLS_LOGIC;
            4'd4, 4'd5, 4'd6, 4'd9, 4'd10:      classify = CLS_ARITH;
            default:                            classify = CLS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       code,
    output logic [WIDTH-1:0] res
);
    localparam int SHW = $clog2(WIDTH);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    always_comb begin
        case (code)
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            OP_BIC:  res = a & ~b;
            OP_SHL:  res = a << shamt;
            OP_SHR:  res = a >> shamt;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_add_unit.sv
module alu_add_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    logic [WIDTH-1:0] low;
    logic [1:0]       top;
    logic             c_into_msb;

    always_comb begin
        low        = {1'b0, x[WIDTH-2:0]} + {1'b0, y[WIDTH-2:0]} + {{(WIDTH-1){1'b0}}, cin};
        c_into_msb = low[WIDTH-1];
        top        = {1'b0, x[WIDTH-1]} + {1'b0, y[WIDTH-1]} + {1'b0, c_into_msb};
        sum        = {top[0], low[WIDTH-2:0]};
        cout       = top[1];
        ovf        = top[1] ^ c_into_msb;
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  flags_t nxt,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= nxt;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       op_code,
    input  logic             set_flags,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);
    flags_t           cur, nxt;
    op_class_e        cls;
    logic [WIDTH-1:0] add_x, add_y, add_sum, logic_res;
    logic             add_cin, add_cout, add_ovf;

    assign cls = classify(op_code);

    always_comb begin
        add_x   = op_a;
        add_y   = op_b;
        add_cin = 1'b0;
        case (op_code)
            OP_SUB: begin add_y = ~op_b; add_cin = 1'b1; end
            OP_RSB: begin add_x = op_b; add_y = ~op_a; add_cin = 1'b1; end
            OP_ADC: add_cin = cur.c;
            OP_SBC: begin add_y = ~op_b; add_cin = cur.c; end
            default: ;
        endcase
    end

    alu_add_unit #(.WIDTH(WIDTH)) u_add (
        .x(add_x), .y(add_y), .cin(add_cin),
        .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a(op_a), .b(op_b), .code(op_code), .res(logic_res)
    );

    always_comb begin
        case (cls)
            CLS_ARITH: result = add_sum;
            CLS_LOGIC: result = logic_res;
            default:   result = '0;
        endcase
        nxt   = cur;
        nxt.n = result[WIDTH-1];
        nxt.z = (result == '0);
        if (cls == CLS_ARITH) begin
            nxt.c = add_cout;
            nxt.v = add_ovf;
        end
    end

    alu_flag_reg u_flags (
        .clk(clk), .rst(rst),
        .load(set_flags && (cls != CLS_NONE)),
        .nxt(nxt), .q(cur)
    );

    assign flag_n = cur.n;
    assign flag_z = cur.z;
    assign flag_c = cur.c;
    assign flag_v = cur.v;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       op_code,
    input logic             set_flags,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_v
);
    logic is_logic, is_defined;
    logic [WIDTH:0] add_wide;
    assign is_logic   = (op_code <= 4'd3) || (op_code == 4'd7) || (op_code == 4'd8);
    assign is_defined = (op_code <= 4'd10);
    assign add_wide   = {1'b0, op_a} + {1'b0, op_b};

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    assert_keep_cv_R8: assert property (@(posedge clk) disable iff (rst)
        (set_flags && is_logic) |=> $stable({flag_c, flag_v}));

    assert_n_msb_R6: assert property (@(posedge clk) disable iff (rst)
        (set_flags && is_defined) |=> (flag_n == $past(result[WIDTH-1])));

    assert_z_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (set_flags && is_defined) |=> (flag_z == ($past(result) == '0)));

    assert_add_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_code == 4'd4) |=> (flag_c == $past(add_wide[WIDTH])));

    assert_undef_result_R11: assert property (@(posedge clk) disable iff (rst)
        !is_defined |-> (result == '0));

    assert_undef_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !is_defined |=> $stable({flag_n, flag_z, flag_c, flag_v}));
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_code(op_code),
    .set_flags(set_flags), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/alu_core_tb.sv
`timescale 1ns/1ps
module alu_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0, op_b = '0;
    logic [3:0]  op_code = '0;
    logic        set_flags = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic m_n = 0, m_z = 0, m_c = 0, m_v = 0;
    logic [31:0] e_res;
    logic e_n, e_z, e_c, e_v;

    always #2.5 clk = ~clk;

    alu_core u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_code(op_code),
        .set_flags(set_flags), .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] s;
        logic [31:0] x, y;
        logic cin;
        bit arith;
        arith = 0; x = a; y = b; cin = 0;
        e_n = m_n; e_z = m_z; e_c = m_c; e_v = m_v;
        case (op)
            0: e_res = a & b;
            1: e_res = a ^ b;
            2: e_res = a | b;
            3: e_res = a & ~b;
            7: e_res = a << b[4:0];
            8: e_res = a >> b[4:0];
            4: begin arith = 1; end
            5: begin arith = 1; y = ~b; cin = 1; end
            6: begin arith = 1; x = b; y = ~a; cin = 1; end
            9: begin arith = 1; cin = m_c; end
            10: begin arith = 1; y = ~b; cin = m_c; end
            default: e_res = 0;
        endcase
        if (arith) begin
            s = {1'b0, x} + {1'b0, y} + {32'd0, cin};
            e_res = s[31:0];
            e_c = s[32];
            e_v = (x[31] == y[31]) && (s[31] != x[31]);
        end
        if (op <= 10) begin
            e_n = e_res[31];
            e_z = (e_res == 0);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sf, input string rq, input string fq);
        @(negedge clk);
        op_a = a; op_b = b; op_code = op; set_flags = sf;
        model(op, a, b);
        #1;
        check(rq, "result", result, e_res);
        @(posedge clk);
        #1;
        if (sf) begin m_n = e_n; m_z = e_z; m_c = e_c; m_v = e_v; end
        check(fq, "flags nzcv", {flag_n, flag_z, flag_c, flag_v}, {m_n, m_z, m_c, m_v});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        m_n = 0; m_z = 0; m_c = 0; m_v = 0;
        check("R10", "flags after reset", {flag_n, flag_z, flag_c, flag_v}, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [31:0] lfsr;
        do_reset();
        // R1 logical ops
        run(0, 32'hF0F0_1234, 32'h0FF0_FF00, 1, "R1", "R6");
        run(1, 32'hAAAA_5555, 32'hFFFF_0000, 1, "R1", "R6");
        run(2, 32'h8000_0000, 32'h0000_0001, 1, "R1", "R6");
        run(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R1", "R6");
        // R4 add wrap, Z and C set
        run(4, 32'hFFFF_FFFF, 32'h1, 1, "R2", "R4");
        // R8 logical op keeps C=1
        run(2, 32'h1, 32'h2, 1, "R1", "R8");
        // R5 signed overflow
        run(4, 32'h7FFF_FFFF, 32'h1, 1, "R2", "R5");
        run(5, 32'h8000_0000, 32'h1, 1, "R2", "R5");
        // R4 subtract borrow semantics
        run(5, 32'd5, 32'd5, 1, "R2", "R4");
        run(5, 32'd3, 32'd5, 1, "R2", "R4");
        run(6, 32'd3, 32'd10, 1, "R2", "R4");
        // R3 two-word add: low words carry into the high words
        run(4, 32'hFFFF_FFF0, 32'h0000_0020, 1, "R2", "R4");
        run(9, 32'h0000_0001, 32'h0000_0002, 1, "R3", "R4");
        // R3 two-word subtract with borrow pending (C=0)
        run(5, 32'h0, 32'h1, 1, "R2", "R4");
        run(10, 32'h10, 32'h1, 1, "R3", "R4");
        // R3 with no borrow pending (C=1)
        run(10, 32'h10, 32'h1, 1, "R3", "R4");
        // R7 shift count uses the low bits only; R8 keeps C,V
        run(4, 32'hFFFF_FFFF, 32'h1, 1, "R2", "R4");
        run(7, 32'h8000_0001, 32'd33, 1, "R7", "R8");
        run(8, 32'h8000_0000, 32'd31, 1, "R7", "R8");
        run(8, 32'h1234_5678, 32'h0000_0100, 1, "R7", "R6");
        // R9 flags held without set_flags
        run(5, 32'd1, 32'd2, 0, "R2", "R9");
        run(0, 32'h0, 32'h0, 0, "R1", "R9");
        // R11 undefined codes
        run(12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R11", "R11");
        run(15, 32'h1234, 32'h1, 1, "R11", "R11");
        // R10 reset mid-run
        run(5, 32'd0, 32'd1, 1, "R2", "R6");
        do_reset();
        // mixed pattern sweep
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            logic [3:0] op;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = (i % 5 == 0) ? ~a : lfsr * 32'd2654435761;
            op = 4'(i % 16);
            run(op, a, b, (i % 7) != 3, "R6", "R9");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule